// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path. When the core raises a take-event strobe, the block looks at three things: a pending synchronous exception code, an interrupt request with its priority level and vector from the interrupt controller, and the core's current architectural state. The state it reads is the status word, the PC, general register 15, the vector base, and the delay-slot and sleep flags. From these it decides in one clock edge whether an exception is entered, an interrupt is entered, a reset is requested, or nothing happens.

When an event is entered, the block captures the status word, the return PC and register 15 into shadow registers. It raises the block, privileged and bank bits of the status word and records the event code. It then presents the target PC. Reset-class exception codes go to a fixed boot address and also reopen the floating-point unit and raise the interrupt mask to its maximum. TLB-miss codes use a separate vector offset from the other exceptions, and interrupts use a third offset. The return PC is corrected for events that hit a delay slot and for the trap instruction. A pulse tells the core to clear its sleep flag, and a second pulse tells it to clear its delay-slot flag. All results are registered and hold their value until the next entry.

Top module: `exc_entry_seq`

## Requirements
- R1: With take_i high, a valid pending exception is always chosen over a simultaneous interrupt request; irq_event_o keeps its value.
- R2: With take_i high, status_i bit 28 (block) set, and a valid exception whose code is not 0x1E0, only reset_req_o pulses on the next cycle. Every registered state output is left unchanged and entry_o stays low.
- R3: While status_i bit 28 is set, interrupt requests are ignored unless sleep_i is high. Every entry pulses sleep_clr_o for one cycle.
- R4: An interrupt is entered only if irq_level_i is strictly greater than the mask in status_i bits 7:4. Otherwise nothing changes.
- R5: On entry, saved_status_o takes status_i and saved_r15_o takes r15_i. status_o becomes status_i with bits 28 (block), 30 (privileged) and 29 (bank) set. entry_o pulses for one cycle.
- R6: When dslot_i is high on entry, saved_pc_o is pc_i minus 2 and dslot_clr_o pulses. Otherwise saved_pc_o is pc_i.
- R7: Exception codes 0x000, 0x020 and 0x140 set new_pc_o to 0xA0000000. They also clear status bit 15 (FPU disable) and force status bits 7:4 to 0xF.
- R8: Exception codes 0x040 and 0x060 set new_pc_o to vbr_i + 0x400. Any other non-reset-class exception sets it to vbr_i + 0x100.
- R9: For exception code 0x160 the saved PC is increased by 2, on top of any delay-slot correction.
- R10: An entered exception writes its code to exc_event_o. An entered interrupt writes irq_vector_i to irq_event_o and sets new_pc_o to vbr_i + 0x600.
- R11: While dslot_i is high no interrupt is entered.
- R12: After reset all outputs are zero. With take_i low no output changes and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Evaluate and perform an entry this cycle |
| exc_valid_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Interrupt controller has a request |
| irq_level_i | input | 4 | Priority level of the request |
| irq_vector_i | input | 12 | Event code of the request |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base |
| dslot_i | input | 1 | Core is in a branch delay slot |
| sleep_i | input | 1 | Core is sleeping |
| status_o | output | 32 | Updated status word |
| saved_status_o | output | 32 | Shadow of the status word |
| saved_pc_o | output | 32 | Shadow (return) PC |
| saved_r15_o | output | 32 | Shadow of register 15 |
| exc_event_o | output | 12 | Last entered exception code |
| irq_event_o | output | 12 | Last entered interrupt code |
| new_pc_o | output | 32 | Target PC of the last entry |
| entry_o | output | 1 | One-cycle pulse: an entry was performed |
| reset_req_o | output | 1 | One-cycle pulse: masked exception escalated to reset |
| sleep_clr_o | output | 1 | One-cycle pulse: clear the sleep flag |
| dslot_clr_o | output | 1 | One-cycle pulse: clear the delay-slot flag |

## Verification
The assertions assume that every input is stable and known at the clock edge where take_i is high. They also assume the outcome is read one cycle later, because all results are registered from that sampled state. The bench meets this by changing inputs only on the falling edge and holding them for exactly one rising edge with the strobe raised. It sweeps every listed exception code against the block and delay-slot flags and a concurrent interrupt. It then sweeps every interrupt level against several mask values and every combination of the block, sleep and delay-slot flags. Idle cycles with the strobe low are placed between vectors.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int XLEN   = 32;
    parameter int CODE_W = 12;
    parameter int LVL_W  = 4;

    // status word bit positions the core's decoder relies on
    localparam int SR_BLOCK   = 28;
    localparam int SR_BANK    = 29;
    localparam int SR_PRIV    = 30;
    localparam int SR_FPOFF   = 15;
    localparam int SR_MASK_LO = 4;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_EXC   = 2'd1,
        EV_IRQ   = 2'd2,
        EV_RESET = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic [XLEN-1:0]   status;
        logic [XLEN-1:0]   saved_status;
        logic [XLEN-1:0]   saved_pc;
        logic [XLEN-1:0]   saved_r15;
        logic [CODE_W-1:0] exc_event;
        logic [CODE_W-1:0] irq_event;
        logic [XLEN-1:0]   pc;
        logic              entry;
        logic              rst_req;
        logic              sleep_clr;
        logic              dslot_clr;
    } seq_state_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] BL_SAFE_CODE = 12'h1E0
) (
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic              blocked_i,
    input  logic [LVL_W-1:0]  imask_i,
    input  logic              dslot_i,
    input  logic              sleep_i,
    output ev_kind_e          kind_o
);
    logic irq_ok;

    // delay slots are indivisible; block bit hides interrupts unless asleep
    assign irq_ok = irq_req_i && !dslot_i && (!blocked_i || sleep_i)
                    && (irq_level_i > imask_i);

    always_comb begin
        kind_o = EV_NONE;
        if (take_i) begin
            if (exc_valid_i) begin
                if (blocked_i && (exc_code_i != BL_SAFE_CODE)) begin
                    kind_o = EV_RESET;
                end else begin
                    kind_o = EV_EXC;
                end
            end else if (irq_ok) begin
                kind_o = EV_IRQ;
            end
        end
    end

    // a_r1_exc_first: exception pending under strobe never yields an interrupt entry
    always_comb begin
        if (take_i && exc_valid_i) begin
            a_r1_exc_first: assert (kind_o != EV_IRQ && kind_o != EV_NONE);
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0]     BOOT_PC     = 32'hA000_0000,
    parameter logic [XLEN-1:0]     OFS_GENERAL = 32'h100,
    parameter logic [XLEN-1:0]     OFS_MISS    = 32'h400,
    parameter logic [XLEN-1:0]     OFS_IRQ     = 32'h600,
    parameter int                  N_BOOT      = 3,
    parameter logic [N_BOOT*CODE_W-1:0] BOOT_CODES = {12'h140, 12'h020, 12'h000},
    parameter int                  N_MISS      = 2,
    parameter logic [N_MISS*CODE_W-1:0] MISS_CODES = {12'h060, 12'h040},
    parameter logic [CODE_W-1:0]   TRAP_CODE   = 12'h160
) (
    input  logic              is_irq_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   status_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              dslot_i,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   saved_pc_o,
    output logic [XLEN-1:0]   new_status_o
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(2);

    logic [N_BOOT-1:0] boot_hit;
    logic [N_MISS-1:0] miss_hit;
    logic              is_boot, is_miss, is_trap;

    for (genvar b = 0; b < N_BOOT; b++) begin : g_boot
        assign boot_hit[b] = (code_i == BOOT_CODES[b*CODE_W +: CODE_W]);
    end
    for (genvar m = 0; m < N_MISS; m++) begin : g_miss
        assign miss_hit[m] = (code_i == MISS_CODES[m*CODE_W +: CODE_W]);
    end

    assign is_boot = !is_irq_i && (|boot_hit);
    assign is_miss = !is_irq_i && (|miss_hit);
    assign is_trap = !is_irq_i && (code_i == TRAP_CODE);

    always_comb begin
        saved_pc_o = pc_i;
        if (dslot_i) saved_pc_o = saved_pc_o - PC_STEP;
        if (is_trap) saved_pc_o = saved_pc_o + PC_STEP;

        new_status_o = status_i;
        new_status_o[SR_BLOCK] = 1'b1;
        new_status_o[SR_PRIV]  = 1'b1;
        new_status_o[SR_BANK]  = 1'b1;

        if (is_irq_i) begin
            new_pc_o = vbr_i + OFS_IRQ;
        end else if (is_boot) begin
            new_pc_o = BOOT_PC;
            new_status_o[SR_FPOFF] = 1'b0;
            new_status_o[SR_MASK_LO +: LVL_W] = '1;
        end else if (is_miss) begin
            new_pc_o = vbr_i + OFS_MISS;
        end else begin
            new_pc_o = vbr_i + OFS_GENERAL;
        end
    end

    // a_r7_boot_mask: reset-class entry always leaves the mask fully raised
    always_comb begin
        if (is_boot) begin
            a_r7_boot_mask: assert (new_status_o[SR_MASK_LO +: LVL_W] == '1
                                    && new_pc_o == BOOT_PC);
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0]   BOOT_PC      = 32'hA000_0000,
    parameter logic [CODE_W-1:0] BL_SAFE_CODE = 12'h1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic [CODE_W-1:0] irq_vector_i,
    input  logic [XLEN-1:0]   status_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              dslot_i,
    input  logic              sleep_i,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   saved_status_o,
    output logic [XLEN-1:0]   saved_pc_o,
    output logic [XLEN-1:0]   saved_r15_o,
    output logic [CODE_W-1:0] exc_event_o,
    output logic [CODE_W-1:0] irq_event_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic              entry_o,
    output logic              reset_req_o,
    output logic              sleep_clr_o,
    output logic              dslot_clr_o
);
    ev_kind_e        kind;
    logic [XLEN-1:0] tgt_pc, tgt_saved_pc, tgt_status;
    seq_state_t      st_d, st_q;

    exc_arbiter #(.BL_SAFE_CODE(BL_SAFE_CODE)) u_arb (
        .take_i      (take_i),
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_req_i   (irq_req_i),
        .irq_level_i (irq_level_i),
        .blocked_i   (status_i[SR_BLOCK]),
        .imask_i     (status_i[SR_MASK_LO +: LVL_W]),
        .dslot_i     (dslot_i),
        .sleep_i     (sleep_i),
        .kind_o      (kind)
    );

    exc_target #(.BOOT_PC(BOOT_PC)) u_tgt (
        .is_irq_i     (kind == EV_IRQ),
        .code_i       (exc_code_i),
        .status_i     (status_i),
        .pc_i         (pc_i),
        .vbr_i        (vbr_i),
        .dslot_i      (dslot_i),
        .new_pc_o     (tgt_pc),
        .saved_pc_o   (tgt_saved_pc),
        .new_status_o (tgt_status)
    );

    always_comb begin
        st_d           = st_q;
        st_d.entry     = 1'b0;
        st_d.rst_req   = 1'b0;
        st_d.sleep_clr = 1'b0;
        st_d.dslot_clr = 1'b0;
        case (kind)
            EV_RESET: st_d.rst_req = 1'b1;
            EV_EXC, EV_IRQ: begin
                st_d.entry        = 1'b1;
                st_d.sleep_clr    = 1'b1;
                st_d.dslot_clr    = dslot_i;
                st_d.saved_status = status_i;
                st_d.saved_pc     = tgt_saved_pc;
                st_d.saved_r15    = r15_i;
                st_d.status       = tgt_status;
                st_d.pc           = tgt_pc;
                if (kind == EV_EXC) st_d.exc_event = exc_code_i;
                else                st_d.irq_event = irq_vector_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o       = st_q.status;
    assign saved_status_o = st_q.saved_status;
    assign saved_pc_o     = st_q.saved_pc;
    assign saved_r15_o    = st_q.saved_r15;
    assign exc_event_o    = st_q.exc_event;
    assign irq_event_o    = st_q.irq_event;
    assign new_pc_o       = st_q.pc;
    assign entry_o        = st_q.entry;
    assign reset_req_o    = st_q.rst_req;
    assign sleep_clr_o    = st_q.sleep_clr;
    assign dslot_clr_o    = st_q.dslot_clr;

    a_r2_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && exc_valid_i && status_i[SR_BLOCK] && exc_code_i != BL_SAFE_CODE)
        |=> (reset_req_o && !entry_o && $stable(saved_pc_o) && $stable(status_o)));

    a_r1_irq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && exc_valid_i) |=> $stable(irq_event_o));

    a_r5_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (status_o[SR_BLOCK] && status_o[SR_PRIV] && status_o[SR_BANK]
                     && sleep_clr_o && !reset_req_o));

    a_r11_no_split: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exc_valid_i && dslot_i) |=> !entry_o);

    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exc_valid_i && irq_level_i <= status_i[SR_MASK_LO +: LVL_W])
        |=> !entry_o);

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> (!entry_o && !reset_req_o && $stable(new_pc_o)));
endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0, exc_v = 1'b0, irq = 1'b0, ds = 1'b0, sl = 1'b0;
    logic [11:0] code = '0, vec = '0;
    logic [3:0]  lvl = '0;
    logic [31:0] st = '0, pc = '0, r15 = '0, vbr = '0;

    logic [31:0] o_st, o_sst, o_spc, o_sr15, o_npc;
    logic [11:0] o_exc, o_irq;
    logic        o_ent, o_rst, o_sclr, o_dclr;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // expected state kept by the bench
    logic [31:0] e_st = '0, e_sst = '0, e_spc = '0, e_sr15 = '0, e_npc = '0;
    logic [11:0] e_exc = '0, e_irq = '0;
    logic        e_ent = 0, e_rst = 0, e_sclr = 0, e_dclr = 0;

    always #10 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .take_i(take), .exc_valid_i(exc_v),
        .exc_code_i(code), .irq_req_i(irq), .irq_level_i(lvl),
        .irq_vector_i(vec), .status_i(st), .pc_i(pc), .r15_i(r15),
        .vbr_i(vbr), .dslot_i(ds), .sleep_i(sl),
        .status_o(o_st), .saved_status_o(o_sst), .saved_pc_o(o_spc),
        .saved_r15_o(o_sr15), .exc_event_o(o_exc), .irq_event_o(o_irq),
        .new_pc_o(o_npc), .entry_o(o_ent), .reset_req_o(o_rst),
        .sleep_clr_o(o_sclr), .dslot_clr_o(o_dclr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference model of the entry rules
    task automatic model;
        bit blk, is_exc, is_irq, boot;
        blk = st[28];
        e_ent = 0; e_rst = 0; e_sclr = 0; e_dclr = 0;
        is_exc = 0; is_irq = 0;
        if (take) begin
            if (exc_v) begin
                if (blk && code != 12'h1E0) e_rst = 1;
                else is_exc = 1;
            end else if (irq && !ds && (!blk || sl) && lvl > st[7:4]) begin
                is_irq = 1;
            end
        end
        if (is_exc || is_irq) begin
            e_ent = 1; e_sclr = 1; e_dclr = ds;
            e_sst = st; e_sr15 = r15;
            e_spc = pc - (ds ? 32'd2 : 32'd0) + ((is_exc && code == 12'h160) ? 32'd2 : 32'd0);
            e_st = st | 32'h7000_0000;
            if (is_irq) begin
                e_irq = vec;
                e_npc = vbr + 32'h600;
            end else begin
                e_exc = code;
                boot = (code == 12'h000 || code == 12'h020 || code == 12'h140);
                if (boot) begin
                    e_st[15] = 1'b0;
                    e_st[7:4] = 4'hF;
                    e_npc = 32'hA000_0000;
                end else if (code == 12'h040 || code == 12'h060) begin
                    e_npc = vbr + 32'h400;
                end else begin
                    e_npc = vbr + 32'h100;
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R5 status"},     o_st,   e_st);
        chk({tag, " R5 saved st"},   o_sst,  e_sst);
        chk({tag, " R6/R9 saved pc"}, o_spc, e_spc);
        chk({tag, " R5 saved r15"},  o_sr15, e_sr15);
        chk({tag, " R10 exc ev"},    32'(o_exc), 32'(e_exc));
        chk({tag, " R1/R10 irq ev"}, 32'(o_irq), 32'(e_irq));
        chk({tag, " R7/R8 new pc"},  o_npc,  e_npc);
        chk({tag, " R4 entry"},      32'(o_ent),  32'(e_ent));
        chk({tag, " R2 reset req"},  32'(o_rst),  32'(e_rst));
        chk({tag, " R3 sleep clr"},  32'(o_sclr), 32'(e_sclr));
        chk({tag, " R6 dslot clr"},  32'(o_dclr), 32'(e_dclr));
    endtask

    // one vector: drive at falling edge, register at rising edge, sample at next fall
    task automatic apply(input string tag, input bit t);
        take = t;
        model();
        @(posedge clk);
        @(negedge clk);
        take = 1'b0;
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] codes [9];
        logic [3:0]  masks [3];
        codes = '{12'h000, 12'h020, 12'h140, 12'h040, 12'h060,
                  12'h160, 12'h0E0, 12'h1E0, 12'h180};
        masks = '{4'h0, 4'h5, 4'hF};
        repeat (3) @(negedge clk);
        // R12: reset state
        check_all("reset R12");
        rst_n = 1'b1;
        @(negedge clk);

        // exceptions against block/delay-slot flags and a concurrent interrupt (R1, R2, R7, R8, R9)
        for (int c = 0; c < 9; c++) begin
            for (int b = 0; b < 2; b++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int q = 0; q < 2; q++) begin
                        exc_v = 1; code = codes[c];
                        irq = q[0]; lvl = 4'hF; vec = 12'h3C0 + 12'(c);
                        st = 32'h0000_8050 | (32'(b) << 28) | (32'(c) << 8);
                        pc = 32'h0C00_1000 + 32'(c * 64 + b * 16 + d * 4);
                        r15 = 32'h8C00_0000 + 32'(c);
                        vbr = 32'h8000_0000 + 32'(c) * 32'h1000;
                        ds = d[0]; sl = 0;
                        apply("exc", 1'b1);
                    end
                end
            end
        end

        // interrupts over every level, several masks, block/sleep/delay slot (R3, R4, R10, R11)
        for (int m = 0; m < 3; m++) begin
            for (int l = 0; l < 16; l++) begin
                for (int f = 0; f < 8; f++) begin
                    exc_v = 0; code = 12'h0E0;
                    irq = 1; lvl = 4'(l); vec = 12'h200 + 12'(l * 32);
                    st = 32'h4000_0000 | (32'(f & 1) << 28) | (32'(masks[m]) << 4);
                    sl = f[1]; ds = f[2];
                    pc = 32'h0000_4000 + 32'(l * 2 + m * 64);
                    r15 = 32'(f);
                    vbr = 32'h8C00_0000;
                    apply("irq", 1'b1);
                end
                // R12: strobe low changes nothing
                irq = 1; lvl = 4'hF; st = '0; exc_v = 1; code = 12'h000;
                apply("idle R12", 1'b0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule